// File: doc/BRIEF.md
# Geometry Point-ROM Host Interface

This block is the host-facing register port of a 3D geometry engine. A host issues single-cycle accesses to eight 16-bit word registers, chosen by a 3-bit offset. Through these registers the host can:

- poll a status word that carries the vertical-blank condition;
- reach a small local scratch RAM through an address register and a data window;
- assemble a 32-bit point-ROM pointer from 16-bit pieces and fetch the pointed 32-bit ROM word as two halves;
- acknowledge the engine's level interrupt.

Read data comes back one clock after the request, qualified by a one-cycle valid pulse. A two-state access machine drives that valid pulse. In `ST_IDLE` no read data is pending. A read request moves the machine to `ST_RDATA` (transition *read-accept*). In `ST_RDATA` the valid flag is raised for exactly one cycle. From there, another read keeps it in `ST_RDATA` (*read-chain*), and anything else returns it to `ST_IDLE` (*read-done*). From `ST_IDLE`, a write or an idle cycle stays in `ST_IDLE` (*idle-hold*).

The ROM contents are written through a separate load port. The ROM answers only below a configurable limit, which may be smaller than the array.

Top module: `geo_host_port`

## Requirements
- R1: While reset is low and in the cycle after it, `rvalid_o` and `irq2_o` are 0 and `rdata_o` is 0x0000. The RAM address and ROM pointer both start at zero.
- R2: A read of offset 0 returns 0x008E when `vblank_i` is 1. It returns 0x808E (bit 15 set) when `vblank_i` is 0.
- R3: Offset 1 holds the 16-bit RAM address and reads it back. On a write, `be_i[0]` enables bits 7:0 and `be_i[1]` enables bits 15:8; bytes with a clear enable keep their value.
- R4: Offset 4 reads or writes the RAM word selected by the low RAM_AW bits of the RAM address, with the same byte-lane enables as R3. The RAM address never changes because of an offset-4 access.
- R5: A write to offset 2 sets the ROM pointer to (old pointer shifted left by 16) OR the written data, keeping 32 bits.
- R6: A write to offset 3 sets the ROM pointer to zero.
- R7: When the pointer is below ROM_LIMIT, a read of offset 5 returns bits 31:16 of the ROM word at the pointer, and a read of offset 6 returns bits 15:0.
- R8: When the pointer is at or above ROM_LIMIT, reads of offsets 5 and 6 both return 0xFFFF.
- R9: A 1 on `irq_src_i` sets `irq2_o` from the next cycle on. A write to offset 7 clears it. When both happen in the same cycle, `irq2_o` is set.
- R10: Read data appears on `rdata_o` one cycle after the request, with `rvalid_o` high in that cycle. Reads of offsets 2, 3 and 7 return 0x0000.
- R11: `rvalid_o` is 1 only in the cycle after a read request. Between reads, `rdata_o` keeps its last value.
- R12: A write to offset 0 changes nothing that the other offsets can observe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank_i | input | 1 | Display is in vertical blank |
| req_i | input | 1 | Access request this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| off_i | input | 3 | Register offset |
| be_i | input | 2 | Byte-lane enables for writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, held between reads |
| rvalid_o | output | 1 | Read data valid pulse |
| irq_src_i | input | 1 | Interrupt-2 set pulse |
| irq2_o | output | 1 | Interrupt-2 level |
| rom_ld_i | input | 1 | ROM load strobe |
| rom_ld_addr_i | input | ROM_AW | ROM load index |
| rom_ld_data_i | input | 32 | ROM load word |

## Verification
The interrupt set pulse and the host's acknowledge write can land in the same clock. The bench provokes this by raising `irq_src_i` in the cycle of an offset-7 write, both while the level is low and while it is already high. It judges the result by the level seen one cycle later, which must stay set. The bench also aligns a pointer clear or shift with an immediately following half-word read, to judge the R8 boundary at exactly ROM_LIMIT−1 and ROM_LIMIT.

// File: rtl/geo_pkg.sv
package geo_pkg;

    typedef enum logic [2:0] {
        OFF_STATUS  = 3'd0,
        OFF_RAMADDR = 3'd1,
        OFF_PSHIFT  = 3'd2,
        OFF_PCLEAR  = 3'd3,
        OFF_RAMDATA = 3'd4,
        OFF_PHI     = 3'd5,
        OFF_PLO     = 3'd6,
        OFF_IRQACK  = 3'd7
    } reg_off_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } port_state_e;

    localparam logic [15:0] STATUS_BASE = 16'h008E;
    localparam int          NLANES      = 2;

endpackage

// File: rtl/geo_ram.sv
module geo_ram #(
    parameter int AW = 6
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [geo_pkg::NLANES-1:0] be,
    input  logic [AW-1:0]             addr,
    input  logic [15:0]               wdata,
    output logic [15:0]               rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < geo_pkg::NLANES; g++) begin : g_lane
        logic [7:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                bank[addr] <= wdata[g*8 +: 8];
            end
        end

        assign rdata[g*8 +: 8] = bank[addr];
    end

endmodule

// File: rtl/geo_prom.sv
module geo_prom #(
    parameter int AW    = 6,
    parameter int LIMIT = 64
) (
    input  logic          clk,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [31:0]   ld_data,
    input  logic [31:0]   rd_addr,
    output logic          in_range,
    output logic [15:0]   hi_o,
    output logic [15:0]   lo_o
);
    localparam int          DEPTH   = 1 << AW;
    localparam logic [31:0] LIMIT_W = 32'(LIMIT);

    logic [31:0] rom [DEPTH];
    logic [31:0] word;

    always_ff @(posedge clk) begin
        if (ld_we) begin
            rom[ld_addr] <= ld_data;
        end
    end

    assign in_range = (rd_addr < LIMIT_W);
    assign word     = rom[rd_addr[AW-1:0]];
    assign hi_o     = in_range ? word[31:16] : 16'hFFFF;
    assign lo_o     = in_range ? word[15:0]  : 16'hFFFF;

endmodule

// File: rtl/geo_irq.sv
module geo_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (set_i) begin
            irq_o <= 1'b1;
        end else if (clr_i) begin
            irq_o <= 1'b0;
        end
    end

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o);                    // R9
    AST_IRQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq_o);       // R9

endmodule

// File: rtl/geo_host_port.sv
module geo_host_port #(
    parameter int RAM_AW    = 6,
    parameter int ROM_AW    = 6,
    parameter int ROM_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vblank_i,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [2:0]        off_i,
    input  logic [1:0]        be_i,
    input  logic [15:0]       wdata_i,
    output logic [15:0]       rdata_o,
    output logic              rvalid_o,
    input  logic              irq_src_i,
    output logic              irq2_o,
    input  logic              rom_ld_i,
    input  logic [ROM_AW-1:0] rom_ld_addr_i,
    input  logic [31:0]       rom_ld_data_i
);
    import geo_pkg::*;

    localparam logic [31:0] LIMIT_W = 32'(ROM_LIMIT);

    port_state_e state_q, state_d;
    reg_off_e    off;
    logic [15:0] ram_addr_q;
    logic [31:0] prom_addr_q;
    logic [15:0] rdata_q;
    logic [15:0] rd_mux;
    logic [15:0] ram_rdata, prom_hi, prom_lo;
    logic        prom_ok;
    logic        rd_req, wr_req;

    assign off    = reg_off_e'(off_i);
    assign rd_req = req_i && !wr_i;
    assign wr_req = req_i &&  wr_i;

    geo_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (wr_req && (off == OFF_RAMDATA)),
        .be    (be_i),
        .addr  (ram_addr_q[RAM_AW-1:0]),
        .wdata (wdata_i),
        .rdata (ram_rdata)
    );

    geo_prom #(.AW(ROM_AW), .LIMIT(ROM_LIMIT)) u_prom (
        .clk      (clk),
        .ld_we    (rom_ld_i),
        .ld_addr  (rom_ld_addr_i),
        .ld_data  (rom_ld_data_i),
        .rd_addr  (prom_addr_q),
        .in_range (prom_ok),
        .hi_o     (prom_hi),
        .lo_o     (prom_lo)
    );

    geo_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_src_i),
        .clr_i (wr_req && (off == OFF_IRQACK)),
        .irq_o (irq2_o)
    );

    // next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = rd_req ? ST_RDATA : ST_IDLE;
            ST_RDATA: state_d = rd_req ? ST_RDATA : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rvalid_o = (state_q == ST_RDATA);
        rdata_o  = rdata_q;
    end

    // read selection
    always_comb begin
        rd_mux = 16'h0000;
        unique case (off)
            OFF_STATUS:  rd_mux = STATUS_BASE | {!vblank_i, 15'h0000};
            OFF_RAMADDR: rd_mux = ram_addr_q;
            OFF_RAMDATA: rd_mux = ram_rdata;
            OFF_PHI:     rd_mux = prom_hi;
            OFF_PLO:     rd_mux = prom_lo;
            default:     rd_mux = 16'h0000;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q     <= '0;
            ram_addr_q  <= '0;
            prom_addr_q <= '0;
        end else begin
            if (rd_req) begin
                rdata_q <= rd_mux;
            end
            if (wr_req) begin
                unique case (off)
                    OFF_RAMADDR: begin
                        for (int b = 0; b < NLANES; b++) begin
                            if (be_i[b]) ram_addr_q[b*8 +: 8] <= wdata_i[b*8 +: 8];
                        end
                    end
                    OFF_PSHIFT: prom_addr_q <= {prom_addr_q[15:0], wdata_i};
                    OFF_PCLEAR: prom_addr_q <= '0;
                    default: ;
                endcase
            end
        end
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid_o);                                         // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid_o);                                       // R11
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && off == OFF_PCLEAR) |=> (prom_addr_q == 32'd0));    // R6
    AST_RAMADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && off == OFF_RAMDATA) |=> $stable(ram_addr_q));       // R4
    AST_ROM_OVER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (off == OFF_PHI || off == OFF_PLO) && prom_addr_q >= LIMIT_W)
        |=> (rdata_o == 16'hFFFF));                                   // R8
    AST_STATUS_VBL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && off == OFF_STATUS) |=> (rdata_o[14:0] == 15'h008E)); // R2

endmodule

// File: tb/geo_host_port_tb_top.sv
module geo_host_port_tb_top;

    localparam int RAM_AW = 6;
    localparam int ROM_AW = 6;
    localparam int LIM    = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vblank_i = 1'b0;
    logic              req_i = 1'b0;
    logic              wr_i = 1'b0;
    logic [2:0]        off_i = '0;
    logic [1:0]        be_i = '0;
    logic [15:0]       wdata_i = '0;
    logic [15:0]       rdata_o;
    logic              rvalid_o;
    logic              irq_src_i = 1'b0;
    logic              irq2_o;
    logic              rom_ld_i = 1'b0;
    logic [ROM_AW-1:0] rom_ld_addr_i = '0;
    logic [31:0]       rom_ld_data_i = '0;

    always #5 clk = ~clk;

    geo_host_port #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW), .ROM_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i), .req_i(req_i), .wr_i(wr_i),
        .off_i(off_i), .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .irq_src_i(irq_src_i), .irq2_o(irq2_o),
        .rom_ld_i(rom_ld_i), .rom_ld_addr_i(rom_ld_addr_i), .rom_ld_data_i(rom_ld_data_i)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    string tag    = "R1";

    // reference model state
    logic [15:0] m_ram [1 << RAM_AW];
    logic [31:0] m_rom [1 << ROM_AW];
    logic [15:0] m_raddr = 0;
    logic [31:0] m_ptr   = 0;
    logic [15:0] m_rd    = 0;
    logic        m_rv    = 0;
    logic        m_irq   = 0;

    function automatic logic [31:0] rom_word(int i);
        return 32'hC0DE_0000 + i * 32'h0001_0003;
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            m_raddr = 0; m_ptr = 0; m_rd = 0; m_rv = 0; m_irq = 0;
        end else begin
            m_rv = req_i && !wr_i;
            if (req_i && !wr_i) begin
                case (off_i)
                    3'd0: m_rd = vblank_i ? 16'h008E : 16'h808E;
                    3'd1: m_rd = m_raddr;
                    3'd4: m_rd = m_ram[m_raddr % (1 << RAM_AW)];
                    3'd5: m_rd = (m_ptr < LIM) ? m_rom[m_ptr % (1 << ROM_AW)][31:16] : 16'hFFFF;
                    3'd6: m_rd = (m_ptr < LIM) ? m_rom[m_ptr % (1 << ROM_AW)][15:0]  : 16'hFFFF;
                    default: m_rd = 16'h0000;
                endcase
            end
            if (req_i && wr_i) begin
                case (off_i)
                    3'd1: begin
                        if (be_i[0]) m_raddr[7:0]  = wdata_i[7:0];
                        if (be_i[1]) m_raddr[15:8] = wdata_i[15:8];
                    end
                    3'd2: m_ptr = (m_ptr << 16) | 32'(wdata_i);
                    3'd3: m_ptr = 0;
                    3'd4: begin
                        if (be_i[0]) m_ram[m_raddr % (1 << RAM_AW)][7:0]  = wdata_i[7:0];
                        if (be_i[1]) m_ram[m_raddr % (1 << RAM_AW)][15:8] = wdata_i[15:8];
                    end
                    default: ;
                endcase
            end
            if (irq_src_i) m_irq = 1'b1;
            else if (req_i && wr_i && off_i == 3'd7) m_irq = 1'b0;
        end
    endtask

    task automatic compare();
        n_run++;
        if (rvalid_o !== m_rv || irq2_o !== m_irq || rdata_o !== m_rd) begin
            n_fail++;
            $display("FAIL %s: rvalid=%0b irq=%0b rdata=%h expected rvalid=%0b irq=%0b rdata=%h",
                     tag, rvalid_o, irq2_o, rdata_o, m_rv, m_irq, m_rd);
        end
    endtask

    // one clock: inputs already set at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        req_i = 0; wr_i = 0; irq_src_i = 0;
    endtask

    task automatic wr(input logic [2:0] o, input logic [15:0] d, input logic [1:0] b = 2'b11);
        req_i = 1; wr_i = 1; off_i = o; wdata_i = d; be_i = b;
        tick();
    endtask

    task automatic rd(input logic [2:0] o);
        req_i = 1; wr_i = 0; off_i = o; be_i = 2'b00;
        tick();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        // load ROM during reset
        for (int i = 0; i < (1 << ROM_AW); i++) begin
            @(negedge clk);
            rom_ld_i = 1; rom_ld_addr_i = ROM_AW'(i); rom_ld_data_i = rom_word(i);
            m_rom[i] = rom_word(i);
        end
        @(negedge clk); rom_ld_i = 0;
        tag = "R1";
        tick(); tick();
        rst_n = 1;
        tick();

        // status with and without vertical blank
        tag = "R2"; vblank_i = 1; rd(0);
        vblank_i = 0; rd(0);
        vblank_i = 1; rd(0); tick();

        // RAM address register with byte lanes
        tag = "R3"; wr(1, 16'h1234); rd(1);
        wr(1, 16'hABCD, 2'b01); rd(1);
        wr(1, 16'h5A00, 2'b10); rd(1);
        wr(1, 16'hFFFF, 2'b00); rd(1);

        // RAM data window
        tag = "R4";
        for (int a = 0; a < 8; a++) begin
            wr(1, 16'(a));
            wr(4, 16'h1000 + 16'(a * 17));
        end
        wr(1, 16'd5); rd(4); rd(4); rd(1);
        wr(4, 16'hEE77, 2'b10); rd(4);
        wr(4, 16'h0099, 2'b01); rd(4); rd(1);
        wr(1, 16'd6); rd(4);
        wr(1, 16'h0045); rd(4);

        // offset 0 writes have no observable effect
        tag = "R12"; wr(0, 16'hFFFF); rd(1); rd(4); rd(5);

        // pointer shift and clear
        tag = "R6"; wr(3, 16'h0000); rd(5); rd(6);
        tag = "R5"; wr(2, 16'd3); rd(5); rd(6);
        wr(2, 16'd7); rd(6);
        tag = "R7"; wr(3, 0); wr(2, 16'(LIM - 1)); rd(5); rd(6);
        wr(3, 0); wr(2, 16'd20); rd(6); rd(5);
        tag = "R8"; wr(3, 0); wr(2, 16'(LIM)); rd(5); rd(6);
        wr(3, 0); wr(2, 16'd63); rd(5); rd(6);
        wr(3, 0); wr(2, 16'd1); wr(2, 16'd2); rd(5); rd(6);
        tag = "R6"; wr(3, 0); rd(5); rd(6);

        // interrupt level
        tag = "R9"; irq_src_i = 1; tick(); tick();
        wr(7, 16'h0000); tick();
        irq_src_i = 1; wr(7, 0); tick();
        irq_src_i = 1; wr(7, 0);
        wr(7, 0); tick();

        // read data timing and unmapped reads
        tag = "R10"; rd(2); rd(3); rd(7);
        tag = "R11"; rd(1); tick(); tick(); wr(1, 16'h0003); tick();
        rd(0); rd(4); rd(6); tick();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule